// File: doc/BRIEF.md
# Synchronizer Reference Mode Controller

This block is the mode controller of a telecom clock synchronizer. It holds the operating state of the loop and moves between seven states. Freerun runs on the local oscillator alone. Two normal states track the primary or the secondary reference. Two commanded holdover states keep the last frequency of the primary or the secondary reference. Two automatic holdover states are entered without any request when the tracked reference stops being valid.

Software or board logic drives a two-bit mode select, a reference select bit and a phase-continuity control bit. Each reference has its own validity flag. On every clock edge the controller applies the request, or ignores it when the request is not allowed. It then registers the new state. It also produces a one-cycle pulse that starts an external time-interval-error corrector on the transitions that need phase continuity, and a one-cycle flag for requests that cannot be carried out.

Top module: `sync_mode_ctrl`

## Requirements
- R1: The request code is {mode_sel[1], mode_sel[0], ref_sel}: 000 asks for normal on primary, 001 for normal on secondary, 010 for holdover on primary, 011 for holdover on secondary, 10x for freerun, and 11x is reserved. The state codes on state_o are 0 freerun, 1 normal primary, 2 normal secondary, 3 holdover primary, 4 holdover secondary, 5 auto-holdover primary and 6 auto-holdover secondary. While rst_n is low the state is freerun, and tie_pulse and bad_req are 0.
- R2: A normal-primary request moves any other state to state 1. The pulse rules are: no tie_pulse when leaving freerun; tie_pulse equal to pc_ctl when leaving holdover primary; tie_pulse high when leaving any other state.
- R3: A normal-secondary request moves any other state to state 2. tie_pulse is high on every such move except the move out of freerun. pc_ctl has no effect on this request.
- R4: A holdover-primary request is carried out only from state 1 or 3, and a holdover-secondary request only from state 2 or 4. The move into holdover gives no tie_pulse. From any other state the request is illegal.
- R5: A freerun request moves every state to state 0, with no tie_pulse and no bad_req, whatever ref_sel is. It takes priority over every other rule.
- R6: If pri_ok is 0 in state 1, the next state is 5. If sec_ok is 0 in state 2, the next state is 6. Neither move gives a pulse. This rule takes priority over every request except freerun.
- R7: A normal request whose reference flag is 0 leaves the state unchanged, with no pulse and no bad_req.
- R8: A request for the state the block is already in changes nothing and gives no pulse.
- R9: An illegal request, including any reserved 11x code, leaves the state unchanged and sets bad_req high for exactly that one cycle.
- R10: A normal request made from state 5 or 6 moves to that normal state when its reference is valid, and fires tie_pulse.
- R11: hold_en is 1 exactly in states 3 to 6. free_en is 1 exactly in state 0. act_ref is 1 in states 2, 4 and 6 and 0 in all other states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Requested operating mode |
| ref_sel | input | 1 | Reference choice: 0 primary, 1 secondary |
| pc_ctl | input | 1 | Phase-continuity control for the move from holdover primary to normal primary |
| pri_ok | input | 1 | Primary reference valid |
| sec_ok | input | 1 | Secondary reference valid |
| state_o | output | 3 | Current state code |
| act_ref | output | 1 | Active reference side |
| hold_en | output | 1 | Any holdover state is active |
| free_en | output | 1 | Freerun state is active |
| tie_pulse | output | 1 | One-cycle start pulse for the error corrector |
| bad_req | output | 1 | One-cycle illegal-request flag |

## Verification
The bench brings the controller into each of the seven states. In each one it applies every request code together with every combination of pc_ctl and the two validity flags. The expected next state and pulses are worked out from the rules above.

The sweep targets the following design faults:
- The move from holdover primary to normal primary must follow pc_ctl. A design that ignores pc_ctl pulses wrongly on one of the two values.
- pc_ctl must not affect a normal-secondary request. A design that lets it gate this move loses corrector pulses.
- A design that checks the request before the reference loss stays in a normal state whose reference has failed.
- A design that accepts holdover requests from the automatic holdover states, or treats the reserved codes as freerun, shows a wrong state with no bad_req.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_FREE  = 3'd0,
        ST_NRM_P = 3'd1,
        ST_NRM_S = 3'd2,
        ST_HLD_P = 3'd3,
        ST_HLD_S = 3'd4,
        ST_AUT_P = 3'd5,
        ST_AUT_S = 3'd6
    } mode_st_e;

    typedef enum logic [2:0] {
        RQ_NRM_P,
        RQ_NRM_S,
        RQ_HLD_P,
        RQ_HLD_S,
        RQ_FREE,
        RQ_RSVD
    } req_e;

    typedef struct packed {
        mode_st_e st;
        logic     tie;
        logic     bad;
    } ctl_s;

endpackage

// File: rtl/sync_mode_req_decode.sv
module sync_mode_req_decode
    import sync_mode_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       ref_sel,
    output req_e       req
);
    always_comb begin
        case (mode_sel)
            2'b00:   req = ref_sel ? RQ_NRM_S : RQ_NRM_P;
            2'b01:   req = ref_sel ? RQ_HLD_S : RQ_HLD_P;
            2'b10:   req = RQ_FREE;
            default: req = RQ_RSVD;
        endcase
    end
endmodule

// File: rtl/sync_mode_next.sv
module sync_mode_next
    import sync_mode_pkg::*;
(
    input  mode_st_e cur,
    input  req_e     req,
    input  logic     pc_ctl,
    input  logic     pri_ok,
    input  logic     sec_ok,
    output ctl_s     nxt
);
    always_comb begin
        nxt.st  = cur;
        nxt.tie = 1'b0;
        nxt.bad = 1'b0;
        if (req == RQ_FREE) begin
            nxt.st = ST_FREE;
        end else if (cur == ST_NRM_P && !pri_ok) begin
            nxt.st = ST_AUT_P;
        end else if (cur == ST_NRM_S && !sec_ok) begin
            nxt.st = ST_AUT_S;
        end else begin
            case (req)
                RQ_NRM_P: begin
                    if (cur != ST_NRM_P && pri_ok) begin
                        nxt.st = ST_NRM_P;
                        case (cur)
                            ST_FREE:  nxt.tie = 1'b0;
                            ST_HLD_P: nxt.tie = pc_ctl;
                            default:  nxt.tie = 1'b1;
                        endcase
                    end
                end
                RQ_NRM_S: begin
                    if (cur != ST_NRM_S && sec_ok) begin
                        nxt.st  = ST_NRM_S;
                        nxt.tie = (cur != ST_FREE);
                    end
                end
                RQ_HLD_P: begin
                    if (cur == ST_NRM_P || cur == ST_HLD_P) nxt.st = ST_HLD_P;
                    else                                    nxt.bad = 1'b1;
                end
                RQ_HLD_S: begin
                    if (cur == ST_NRM_S || cur == ST_HLD_S) nxt.st = ST_HLD_S;
                    else                                    nxt.bad = 1'b1;
                end
                default: nxt.bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sync_mode_out.sv
module sync_mode_out
    import sync_mode_pkg::*;
(
    input  mode_st_e st,
    output logic     act_ref,
    output logic     hold_en,
    output logic     free_en
);
    always_comb begin
        act_ref = (st == ST_NRM_S) || (st == ST_HLD_S) || (st == ST_AUT_S);
        hold_en = (st == ST_HLD_P) || (st == ST_HLD_S) ||
                  (st == ST_AUT_P) || (st == ST_AUT_S);
        free_en = (st == ST_FREE);
    end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
    import sync_mode_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_sel,
    input  logic            ref_sel,
    input  logic            pc_ctl,
    input  logic            pri_ok,
    input  logic            sec_ok,
    output logic [ST_W-1:0] state_o,
    output logic            act_ref,
    output logic            hold_en,
    output logic            free_en,
    output logic            tie_pulse,
    output logic            bad_req
);
    req_e req;
    ctl_s ctl_d, ctl_q;

    sync_mode_req_decode u_dec (
        .mode_sel (mode_sel),
        .ref_sel  (ref_sel),
        .req      (req)
    );

    sync_mode_next u_nxt (
        .cur    (ctl_q.st),
        .req    (req),
        .pc_ctl (pc_ctl),
        .pri_ok (pri_ok),
        .sec_ok (sec_ok),
        .nxt    (ctl_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: ST_FREE, tie: 1'b0, bad: 1'b0};
        else        ctl_q <= ctl_d;
    end

    sync_mode_out u_out (
        .st      (ctl_q.st),
        .act_ref (act_ref),
        .hold_en (hold_en),
        .free_en (free_en)
    );

    assign state_o   = ctl_q.st;
    assign tie_pulse = ctl_q.tie;
    assign bad_req   = ctl_q.bad;

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tie_pulse, bad_req}));  // R9

    AST_BAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |-> $stable(state_o));  // R9

    AST_TIE_ONLY_INTO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        tie_pulse |-> (state_o == ST_NRM_P || state_o == ST_NRM_S));  // R2

    AST_FREE_NO_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> !tie_pulse);  // R5

    AST_PRI_ENTRY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NRM_P && $past(state_o) != ST_NRM_P) |-> $past(pri_ok));  // R7

    AST_PRI_LOSS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NRM_P && !pri_ok && mode_sel != 2'b10) |=> state_o == ST_AUT_P);  // R6

    AST_SEC_LOSS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NRM_S && !sec_ok && mode_sel != 2'b10) |=> state_o == ST_AUT_S);  // R6

    AST_HOLD_NOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_en && free_en));  // R11
endmodule

// File: tb/sync_mode_ctrl_bench.sv
module sync_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic       ref_sel = 1'b0;
    logic       pc_ctl = 1'b0;
    logic       pri_ok = 1'b1;
    logic       sec_ok = 1'b1;
    logic [2:0] state_o;
    logic       act_ref, hold_en, free_en, tie_pulse, bad_req;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    sync_mode_ctrl u_sync_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_sel(ref_sel),
        .pc_ctl(pc_ctl), .pri_ok(pri_ok), .sec_ok(sec_ok), .state_o(state_o),
        .act_ref(act_ref), .hold_en(hold_en), .free_en(free_en),
        .tie_pulse(tie_pulse), .bad_req(bad_req)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(input int code, input bit pc, input bit p, input bit s);
        @(negedge clk);
        mode_sel = code[2:1];
        ref_sel  = code[0];
        pc_ctl   = pc;
        pri_ok   = p;
        sec_ok   = s;
        @(posedge clk);
        #1;
    endtask

    function automatic void model(input int cur, input int code, input bit pc,
                                  input bit p, input bit s, output int nst,
                                  output bit tie, output bit bad, output string tag);
        bit m2, m1, rs;
        m2 = code[2]; m1 = code[1]; rs = code[0];
        nst = cur; tie = 0; bad = 0; tag = "R8";
        if (m2 && !m1) begin
            nst = 0; tag = "R5";
        end else if (cur == 1 && !p) begin
            nst = 5; tag = "R6";
        end else if (cur == 2 && !s) begin
            nst = 6; tag = "R6";
        end else if (m2 && m1) begin
            bad = 1; tag = "R9";
        end else if (!m1 && !rs) begin
            if (cur == 1) tag = "R8";
            else if (!p) tag = "R7";
            else begin
                nst = 1;
                tie = (cur == 0) ? 1'b0 : (cur == 3) ? pc : 1'b1;
                tag = (cur >= 5) ? "R10" : "R2";
            end
        end else if (!m1 && rs) begin
            if (cur == 2) tag = "R8";
            else if (!s) tag = "R7";
            else begin
                nst = 2;
                tie = (cur != 0);
                tag = (cur >= 5) ? "R10" : "R3";
            end
        end else begin
            tag = "R4";
            if (!rs) begin
                if (cur == 1 || cur == 3) nst = 3; else bad = 1;
            end else begin
                if (cur == 2 || cur == 4) nst = 4; else bad = 1;
            end
        end
    endfunction

    task automatic goto_state(input int st);
        drive(4, 0, 1, 1);
        case (st)
            1: drive(0, 0, 1, 1);
            2: drive(1, 0, 1, 1);
            3: begin drive(0, 0, 1, 1); drive(2, 0, 1, 1); end
            4: begin drive(1, 0, 1, 1); drive(3, 0, 1, 1); end
            5: begin drive(0, 0, 1, 1); drive(0, 0, 0, 1); end
            6: begin drive(1, 0, 1, 1); drive(1, 0, 1, 0); end
            default: ;
        endcase
        chk("R1", "setup state", int'(state_o), st);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset state", int'(state_o), 0);
        chk("R1", "reset tie", int'(tie_pulse), 0);
        chk("R1", "reset bad", int'(bad_req), 0);
        chk("R11", "reset free_en", int'(free_en), 1);
        chk("R11", "reset hold_en", int'(hold_en), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int st = 0; st < 7; st++) begin
            for (int code = 0; code < 8; code++) begin
                for (int v = 0; v < 8; v++) begin
                    int    nst;
                    bit    et, eb;
                    string tag;
                    goto_state(st);
                    model(st, code, v[2], v[1], v[0], nst, et, eb, tag);
                    drive(code, v[2], v[1], v[0]);
                    chk(tag, "state", int'(state_o), nst);
                    chk(tag, "tie_pulse", int'(tie_pulse), int'(et));
                    chk(tag, "bad_req", int'(bad_req), int'(eb));
                    chk("R11", "hold_en", int'(hold_en), int'(nst >= 3));
                    chk("R11", "free_en", int'(free_en), int'(nst == 0));
                    chk("R11", "act_ref", int'(act_ref),
                        int'(nst == 2 || nst == 4 || nst == 6));
                end
            end
        end

        // R9: the flag lasts one cycle once a legal request follows
        goto_state(0);
        drive(6, 0, 1, 1);
        chk("R9", "bad set", int'(bad_req), 1);
        drive(4, 0, 1, 1);
        chk("R9", "bad one cycle", int'(bad_req), 0);
        // R2: the corrector pulse lasts one cycle
        goto_state(2);
        drive(0, 0, 1, 1);
        chk("R2", "tie set", int'(tie_pulse), 1);
        drive(0, 0, 1, 1);
        chk("R2", "tie one cycle", int'(tie_pulse), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule